// File: doc/BRIEF.md
# Stereo Serial Sample Receiver

This block takes two audio channels that arrive one bit at a time on two separate serial pins. Both pins are clocked by a slow data clock and share one frame strobe. The strobe marks slot 0 of a word. The next fifteen data-clock edges fill slots 1 to 15. One 16-bit two's-complement word is built per channel, with the sign in slot 0 and the rest of the bits following most significant first. The two channels are captured together, so a frame always yields a matched left/right pair.

When the sixteenth bit is in, the pair is frozen in a holding register on the data-clock side. The system clock runs much faster than the data clock. A toggle flag carries the news into the system-clock domain through a two-flop synchroniser. There the pair is registered onto the output buses, together with a one-cycle valid pulse.

The same path also carries configuration words, such as shift-count and coefficient words. The block treats every word alike and leaves its meaning to the logic downstream.

Top module: `stereo_frame_rx`

## Requirements
- R1: While `rst_n` is low at a system-clock edge, the next cycle shows `word_valid` = 0 and both output words = 0.
- R2: The bit sampled on the data-clock rising edge where `frame_sync` is high becomes bit 15 (the sign) of the word. The bit from each following edge lands one position lower, so slot 15 ends up in bit 0.
- R3: `ser_left` fills `word_left` and `ser_right` fills `word_right` on the same edges. One pulse presents both words of the same frame.
- R4: Each completed 16-bit frame produces exactly one `word_valid` pulse, and that pulse lasts one system-clock cycle.
- R5: `word_left` and `word_right` change only in a cycle where `word_valid` is high. Otherwise they hold the last delivered pair.
- R6: Serial bits that arrive after a word is complete and before the next strobe are ignored and raise no pulse.
- R7: If `frame_sync` is seen high before 16 bits are collected, the partial word is dropped with no pulse. Counting restarts at slot 0 on that edge.
- R8: If `frame_sync` stays high over several data-clock edges, the last high edge is slot 0. Bits taken on the earlier high edges are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both clock domains |
| dclk | input | 1 | Serial data clock; bits are sampled on its rising edge |
| frame_sync | input | 1 | Frame strobe; high marks slot 0 |
| ser_left | input | 1 | Left-channel serial data |
| ser_right | input | 1 | Right-channel serial data |
| word_valid | output | 1 | One-cycle pulse when a new pair is on the word buses |
| word_left | output | 16 | Last received left word, two's complement |
| word_right | output | 16 | Last received right word, two's complement |

## Verification
The assertions take the data clock to be at least several times slower than `clk`. Under that assumption, two completed words can never come closer than 16 system cycles apart. They also take `rst_n` to be held low across at least two data-clock rising edges, so both domains see it.

The bench runs the data clock at one eighth of the system rate. Its edges are offset from the `clk` edges. Reset is held for 24 system cycles. All serial inputs change only on the falling data-clock edge.

// File: rtl/srx_pkg.sv
// Shared constants for the stereo serial sample receiver.
// Assumes exactly two channels, indexed left then right.
package srx_pkg;
    localparam int NUM_CH   = 2;
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;
endpackage

// File: rtl/srx_slot_ctr.sv
// Slot counter for the data-clock domain. It restarts at slot 0 on every
// edge that sees the frame strobe high. It advances one slot per edge
// while a word is open, and signals completion on the last slot.
// Assumes WORD_W >= 3. With no open word, the counter rests at zero.
module srx_slot_ctr #(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic dclk,
    input  logic rst_n,
    input  logic frame_sync,
    output logic start,
    output logic shift,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_q;

    // Decode the edge type from the strobe and the current slot count.
    always_comb begin
        start = frame_sync;
        shift = !frame_sync && (cnt_q != '0);
        done  = shift && (cnt_q == LAST_SLOT);
    end

    // Track how many bits of the open word have been sampled.
    always_ff @(posedge dclk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(1);
        else if (done)
            cnt_q <= '0;
        else if (shift)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/srx_chan_shift.sv
// Per-channel deserialiser in the data-clock domain. It shifts bits in
// MSB-first and copies the finished word to a holding register.
// Assumes the controls come from srx_slot_ctr. The holding register
// changes only when a word completes.
module srx_chan_shift #(
    parameter int WORD_W = 16
) (
    input  logic              dclk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift,
    input  logic              done,
    input  logic              ser_bit,
    output logic [WORD_W-1:0] hold_word
);
    logic [WORD_W-2:0] sh_q;

    // Gather the leading WORD_W-1 bits of the open word.
    always_ff @(posedge dclk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (start)
            sh_q <= {{(WORD_W-2){1'b0}}, ser_bit};
        else if (shift)
            sh_q <= {sh_q[WORD_W-3:0], ser_bit};
    end

    // Freeze the full word once its final bit arrives.
    always_ff @(posedge dclk) begin
        if (!rst_n)
            hold_word <= '0;
        else if (done)
            hold_word <= {sh_q, ser_bit};
    end
endmodule

// File: rtl/srx_toggle_sync.sv
// Carries a completion event from the data clock to the system clock.
// The source flips a flag once per event. The destination passes the flag
// through SYNC_STAGES flops and pulses for one cycle on each change.
// Assumes events are spaced far beyond SYNC_STAGES+1 system cycles.
module srx_toggle_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic dclk,
    input  logic clk,
    input  logic rst_n,
    input  logic event_in,
    output logic pulse_out
);
    logic                 flag_q;
    logic [SYNC_STAGES:0] sync_q;

    // Flip the source flag once per completed word.
    always_ff @(posedge dclk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (event_in)
            flag_q <= ~flag_q;
    end

    // Resynchronise the flag and keep one extra stage as history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-1:0], flag_q};
    end

    // Detect a change between the last synchronised stage and its history.
    always_comb pulse_out = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/stereo_frame_rx.sv
// Top level of the stereo serial sample receiver. One slot counter drives
// a deserialiser per channel in lockstep. A toggle synchroniser moves the
// completion event to clk, where the pair is registered with a valid pulse.
// Assumes dclk is several times slower than clk, and rst_n is held low
// across at least two dclk rising edges.
module stereo_frame_rx #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dclk,
    input  logic              frame_sync,
    input  logic              ser_left,
    input  logic              ser_right,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_left,
    output logic [WORD_W-1:0] word_right
);
    import srx_pkg::*;

    logic              start, shift, done, got_word;
    logic [NUM_CH-1:0] ser_bits;
    logic [WORD_W-1:0] hold_words [NUM_CH];

    // Gather the serial pins into a channel-indexed vector.
    always_comb begin
        ser_bits[CH_LEFT]  = ser_left;
        ser_bits[CH_RIGHT] = ser_right;
    end

    srx_slot_ctr #(.WORD_W(WORD_W)) u_ctr (
        .dclk       (dclk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .start      (start),
        .shift      (shift),
        .done       (done)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        srx_chan_shift #(.WORD_W(WORD_W)) u_shift (
            .dclk      (dclk),
            .rst_n     (rst_n),
            .start     (start),
            .shift     (shift),
            .done      (done),
            .ser_bit   (ser_bits[ch]),
            .hold_word (hold_words[ch])
        );
    end

    srx_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .dclk      (dclk),
        .clk       (clk),
        .rst_n     (rst_n),
        .event_in  (done),
        .pulse_out (got_word)
    );

    // Register the stable held pair and the valid pulse in the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_left  <= '0;
            word_right <= '0;
        end else begin
            word_valid <= got_word;
            if (got_word) begin
                word_left  <= hold_words[CH_LEFT];
                word_right <= hold_words[CH_RIGHT];
            end
        end
    end
endmodule

// File: rtl/stereo_frame_rx_chk.sv
// Property checker for stereo_frame_rx, attached with bind. It watches the
// system-clock side of the ports only. It assumes the data clock is
// several times slower than clk, so completed words are at least
// WORD_W system cycles apart.
module stereo_frame_rx_chk #(
    parameter int WORD_W = 16,
    localparam int GAP_W = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_left,
    input logic [WORD_W-1:0] word_right
);
    logic [GAP_W-1:0] gap_q;

    // Count system cycles since the last pulse, saturating at WORD_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (word_valid)
            gap_q <= '0;
        else if (gap_q != GAP_W'(WORD_W))
            gap_q <= gap_q + GAP_W'(1);
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!word_valid && word_left == '0 && word_right == '0));

    assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_pulse_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(rst_n)) |-> (gap_q == GAP_W'(WORD_W) || gap_q == '0));

    assert_hold_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_left));

    assert_hold_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_right));
endmodule

bind stereo_frame_rx stereo_frame_rx_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_left  (word_left),
    .word_right (word_right)
);

// File: tb/stereo_frame_rx_tb_top.sv
// Scoreboard bench for stereo_frame_rx. Driver tasks push expected pairs.
// A monitor on the falling clk edge pops and compares them.
module stereo_frame_rx_tb_top;
    localparam int W = 16;

    logic clk = 1'b0;
    logic dclk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_sync = 1'b0;
    logic ser_left = 1'b0;
    logic ser_right = 1'b0;
    logic word_valid;
    logic [W-1:0] word_left, word_right;

    int tests = 0;
    int fails = 0;
    int pulses_seen = 0;
    int pulses_exp = 0;
    bit finished = 0;
    logic [W-1:0] q_left[$];
    logic [W-1:0] q_right[$];

    always #2.5 clk = ~clk;
    always #20 dclk = ~dclk;

    stereo_frame_rx #(.WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dclk(dclk), .frame_sync(frame_sync),
        .ser_left(ser_left), .ser_right(ser_right),
        .word_valid(word_valid), .word_left(word_left), .word_right(word_right)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive nbits slots of a frame starting with a strobe edge.
    task automatic send_bits(input logic [W-1:0] l, input logic [W-1:0] r,
                             input int nbits, input bit strobe);
        for (int i = 0; i < nbits; i++) begin
            @(negedge dclk);
            frame_sync = strobe && (i == 0);
            ser_left   = l[W-1-i];
            ser_right  = r[W-1-i];
        end
    endtask

    task automatic send_word(input logic [W-1:0] l, input logic [W-1:0] r);
        q_left.push_back(l);
        q_right.push_back(r);
        pulses_exp++;
        send_bits(l, r, W, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge dclk);
            frame_sync = 1'b0;
            ser_left   = 1'b1;
            ser_right  = 1'b0;
        end
    endtask

    // Monitor: compare each pulse, then check pulse width and hold.
    always @(negedge clk) begin
        if (rst_n && word_valid && !finished) begin
            logic [W-1:0] el, er;
            pulses_seen++;
            if (q_left.size() == 0) begin
                tests++; fails++;
                $display("FAIL R6/R7: unexpected pulse, actual %h/%h expected none",
                         word_left, word_right);
            end else begin
                el = q_left.pop_front();
                er = q_right.pop_front();
                check("R2 left word", word_left, el);
                check("R3 right word", word_right, er);
            end
            @(negedge clk);
            check("R4 pulse width", {15'b0, word_valid}, 16'h0);
            el = word_left;
            er = word_right;
            repeat (4) @(negedge clk);
            check("R5 left hold", word_left, el);
            check("R5 right hold", word_right, er);
        end
    end

    initial begin
        repeat (24) @(negedge clk);
        check("R1 valid in reset", {15'b0, word_valid}, 16'h0);
        check("R1 left in reset", word_left, 16'h0);
        check("R1 right in reset", word_right, 16'h0);
        rst_n = 1'b1;

        // R2/R3: distinct patterns, sign and MSB positions
        send_word(16'h8000, 16'h0001);
        send_word(16'h7FFF, 16'hFFFF);
        send_word(16'h1234, 16'hA5C3);
        idle(4);
        // R6: bits with no strobe after a complete word
        send_bits(16'hFFFF, 16'hFFFF, W, 1'b0);
        idle(4);
        check("R6 pulse count", 16'(pulses_seen), 16'(pulses_exp));
        // R7: partial word dropped, then a full word right after
        send_bits(16'hDEAD, 16'hBEEF, 10, 1'b1);
        send_word(16'h0F0F, 16'hF0F0);
        // R7: strobe on the very last slot position restarts
        send_bits(16'h5555, 16'h5555, W-1, 1'b1);
        send_word(16'hC001, 16'h3FFE);
        // R8: strobe held over three edges, last one is slot 0
        for (int i = 0; i < 2; i++) begin
            @(negedge dclk);
            frame_sync = 1'b1; ser_left = 1'b0; ser_right = 1'b1;
        end
        send_word(16'hFACE, 16'h0B0E);
        // Back-to-back words
        send_word(16'h0000, 16'h8001);
        send_word(16'hFFFE, 16'h4000);
        idle(6);
        check("R4 total pulses", 16'(pulses_seen), 16'(pulses_exp));
        check("R4 queue drained", 16'(q_left.size()), 16'h0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule